// File: doc/BRIEF.md
# Peripheral Access Firewall Checker

This block stands between bus initiators and a bank of peripheral register slots. It decides, for every access, whether that access may reach its target. Each request carries a compartment identifier (CID, 3 bits), a secure bit, a privileged bit, a slot index and a read/write flag. The block judges the request against a per-slot protection entry and returns a registered verdict one cycle later. A granted write is forwarded to the slot as a one-hot write strobe. A granted read returns the slot's data. A blocked access returns zero, is never forwarded, and raises a one-cycle illegal-access pulse that also captures the offending CID and slot index.

A separate configuration port reads and programs the entries. Every slot has two words. At address `2*idx` sits the control word. At address `2*idx+1` sits the semaphore word, which is taken by reading it and released by writing it. Each entry runs a two-state semaphore machine:

- `SEM_FREE` moves to `SEM_HELD` on transition FREE_TAKE, when a listed CID reads the semaphore word.
- `SEM_HELD` moves back to `SEM_FREE` on transition HELD_RELEASE, when the holder writes 0.
- `SEM_HELD` also moves to `SEM_FREE` on transition HELD_DISABLE, when semaphore filtering is switched off.

Control word layout:

| Bits | Field |
|------|-------|
| 0 | secure-only |
| 1 | privileged-only |
| 2 | CID filter enable |
| 3 | semaphore mode |
| 6:4 | static CID |
| 7 | lock |
| 15:8 | bitmap of CIDs allowed to take the semaphore |

Top module: `pfw_top`

## Requirements
- R1: After reset every control word reads 0x0000, so any CID in any mode is granted on every slot. A granted read returns that slot's data.
- R2: A non-secure access to a slot whose bit 0 is set is blocked.
- R3: An unprivileged access to a slot whose bit 1 is set is blocked.
- R4: With bit 2 set and bit 3 clear, only an access whose CID equals bits 6:4 is granted.
- R5: Reading the semaphore word (bit 0 of the read data) returns 1 and takes the semaphore in two cases: bits 2 and 3 are set, the reader's CID bit is set in bits 15:8, and the semaphore is free; or the reader already holds it. Otherwise the read returns 0 and the state does not change.
- R6: In semaphore mode only the current holder is granted. An access while the semaphore is free is blocked. Writing 0 to the semaphore word frees it only when the writer is the holder.
- R7: A whole control word is written only by the trusted CID (parameter, default 1) with the secure bit set. Writes from any other source leave the filtering fields unchanged.
- R8: A non-trusted initiator that would be granted on the slot may write bit 0 if it is secure, and bit 1 if it is privileged. No other field changes.
- R9: Once bit 7 is set, the control word ignores every write until reset.
- R10: A blocked access returns read data 0, raises no write strobe, and pulses `ill_pulse` for exactly one cycle. It also loads `ill_cid` and `ill_idx`, which hold until the next blocked access.
- R11: A request at one clock edge is answered at the next edge. A granted write raises only the target's bit of `slot_we` and presents the write data on `slot_wdata`.
- R12: Any initiator, of any security or privilege level, may read any control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | access request strobe |
| req_cid | input | 3 | requester CID |
| req_sec | input | 1 | requester is secure |
| req_priv | input | 1 | requester is privileged |
| req_idx | input | IDX_W | target slot |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | write data |
| slot_rdata | input | NP*DW | read data of every slot, slot i at bits i*DW |
| slot_we | output | NP | one-hot write strobe to the slots |
| slot_wdata | output | DW | write data to the slots |
| rsp_valid | output | 1 | verdict valid |
| rsp_grant | output | 1 | 1 = granted, 0 = blocked |
| rsp_rdata | output | DW | read data (zero when blocked) |
| ill_pulse | output | 1 | one-cycle blocked-access flag |
| ill_cid | output | 3 | CID of the last blocked access |
| ill_idx | output | IDX_W | slot of the last blocked access |
| cfg_valid | input | 1 | configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | IDX_W+1 | {slot index, word select} |
| cfg_wdata | input | 16 | configuration write data |
| cfg_cid | input | 3 | configuring initiator CID |
| cfg_sec | input | 1 | configuring initiator is secure |
| cfg_priv | input | 1 | configuring initiator is privileged |
| cfg_rvalid | output | 1 | configuration read data valid |
| cfg_rdata | output | 16 | configuration read data |

## Verification
A configuration write and a data access to the same slot can land in the same clock cycle. The access must then be judged against the entry as it stood before that edge, and the new setting applies only from the next request. The bench provokes this by having the trusted CID turn a CID-filtered slot into a secure-only slot at the same edge where the matching CID makes a non-secure read. It expects that read to be granted and an identical read one cycle later to be blocked. The same ordering applies to a semaphore take and an access in one cycle, which the semaphore sequence exercises through consecutive operations.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
    localparam int CID_W = 3;
    localparam int NCID  = 1 << CID_W;
    localparam int CFG_W = 16;

    // control word; the layout is visible to software through the config port
    typedef struct packed {
        logic [NCID-1:0]  wl;     // CIDs allowed to take the semaphore
        logic             lock;
        logic [CID_W-1:0] cid;    // static owner
        logic             semen;
        logic             cfen;
        logic             priv;
        logic             sec;
    } pfw_ctl_t;

    function automatic logic pfw_allow(
        input pfw_ctl_t         c,
        input logic [CID_W-1:0] cid,
        input logic             sec,
        input logic             priv,
        input logic             held,
        input logic [CID_W-1:0] holder
    );
        logic ok;
        ok = !(c.sec && !sec) && !(c.priv && !priv);
        if (c.cfen) begin
            if (c.semen) ok = ok && held && (holder == cid);
            else         ok = ok && (c.cid == cid);
        end
        return ok;
    endfunction
endpackage

// File: rtl/pfw_entry.sv
module pfw_entry
    import pfw_pkg::*;
#(
    parameter int TRUST_CID = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             sem_take,
    input  logic             sem_wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic [CID_W-1:0] w_cid,
    input  logic             w_sec,
    input  logic             w_priv,
    output pfw_ctl_t         ctl,
    output logic             held,
    output logic [CID_W-1:0] holder,
    output logic             take_ok
);
    typedef enum logic {SEM_FREE, SEM_HELD} sem_st_t;

    sem_st_t          st, st_nx;
    logic [CID_W-1:0] holder_nx;
    pfw_ctl_t         ctl_nx;
    logic             mode, trusted, may;

    assign mode    = ctl.cfen && ctl.semen;
    assign held    = (st == SEM_HELD);
    assign take_ok = mode && ctl.wl[w_cid] && (st == SEM_FREE || holder == w_cid);
    assign trusted = (w_cid == CID_W'(TRUST_CID)) && w_sec;
    assign may     = pfw_allow(ctl, w_cid, w_sec, w_priv, held, holder);

    // semaphore state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= SEM_FREE;
            holder <= '0;
        end else begin
            st     <= st_nx;
            holder <= holder_nx;
        end
    end

    // semaphore transitions
    always_comb begin
        st_nx     = st;
        holder_nx = holder;
        unique case (st)
            SEM_FREE: begin
                if (sem_take && take_ok) begin       // FREE_TAKE
                    st_nx     = SEM_HELD;
                    holder_nx = w_cid;
                end
            end
            SEM_HELD: begin
                if (!mode)                           // HELD_DISABLE
                    st_nx = SEM_FREE;
                else if (sem_wr && !wdata[0] && holder == w_cid)  // HELD_RELEASE
                    st_nx = SEM_FREE;
            end
            default: st_nx = SEM_FREE;
        endcase
    end

    // control word update
    always_comb begin
        ctl_nx = ctl;
        if (ctl_we && !ctl.lock) begin
            if (trusted) begin
                ctl_nx = pfw_ctl_t'(wdata);
            end else if (may) begin
                if (w_sec)  ctl_nx.sec  = wdata[0];
                if (w_priv) ctl_nx.priv = wdata[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl <= '0;
        else        ctl <= ctl_nx;
    end
endmodule

// File: rtl/pfw_resp.sv
module pfw_resp
    import pfw_pkg::*;
#(
    parameter int NP    = 4,
    parameter int DW    = 8,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CID_W-1:0] req_cid,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [DW-1:0]    req_wdata,
    input  logic             ok,
    input  logic [DW-1:0]    sel_rdata,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic [DW-1:0]    rsp_rdata,
    output logic [NP-1:0]    slot_we,
    output logic [DW-1:0]    slot_wdata,
    output logic             ill_pulse,
    output logic [CID_W-1:0] ill_cid,
    output logic [IDX_W-1:0] ill_idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_grant  <= 1'b0;
            rsp_rdata  <= '0;
            slot_we    <= '0;
            slot_wdata <= '0;
            ill_pulse  <= 1'b0;
            ill_cid    <= '0;
            ill_idx    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && ok;
            rsp_rdata <= (req_valid && ok && !req_write) ? sel_rdata : '0;
            ill_pulse <= req_valid && !ok;
            for (int i = 0; i < NP; i++)
                slot_we[i] <= req_valid && ok && req_write && (req_idx == IDX_W'(i));
            if (req_valid && ok && req_write)
                slot_wdata <= req_wdata;
            if (req_valid && !ok) begin
                ill_cid <= req_cid;
                ill_idx <= req_idx;
            end
        end
    end
endmodule

// File: rtl/pfw_top.sv
module pfw_top
    import pfw_pkg::*;
#(
    parameter int NP        = 4,
    parameter int DW        = 8,
    parameter int TRUST_CID = 1,
    parameter int IDX_W     = $clog2(NP)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [CID_W-1:0]    req_cid,
    input  logic                req_sec,
    input  logic                req_priv,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic                req_write,
    input  logic [DW-1:0]       req_wdata,
    input  logic [NP*DW-1:0]    slot_rdata,
    output logic [NP-1:0]       slot_we,
    output logic [DW-1:0]       slot_wdata,
    output logic                rsp_valid,
    output logic                rsp_grant,
    output logic [DW-1:0]       rsp_rdata,
    output logic                ill_pulse,
    output logic [CID_W-1:0]    ill_cid,
    output logic [IDX_W-1:0]    ill_idx,
    input  logic                cfg_valid,
    input  logic                cfg_write,
    input  logic [IDX_W:0]      cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [CID_W-1:0]    cfg_cid,
    input  logic                cfg_sec,
    input  logic                cfg_priv,
    output logic                cfg_rvalid,
    output logic [CFG_W-1:0]    cfg_rdata
);
    pfw_ctl_t [NP-1:0]            ent_ctl;
    logic     [NP-1:0]            ent_held;
    logic     [NP-1:0][CID_W-1:0] ent_holder;
    logic     [NP-1:0]            ent_take_ok;

    logic [IDX_W-1:0] cfg_idx;
    logic             cfg_sel;
    assign cfg_idx = cfg_addr[IDX_W:1];
    assign cfg_sel = cfg_addr[0];

    for (genvar g = 0; g < NP; g++) begin : g_ent
        logic hit;
        assign hit = cfg_valid && (cfg_idx == IDX_W'(g));
        pfw_entry #(.TRUST_CID(TRUST_CID)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   (hit && cfg_write && !cfg_sel),
            .sem_take (hit && !cfg_write && cfg_sel),
            .sem_wr   (hit && cfg_write && cfg_sel),
            .wdata    (cfg_wdata),
            .w_cid    (cfg_cid),
            .w_sec    (cfg_sec),
            .w_priv   (cfg_priv),
            .ctl      (ent_ctl[g]),
            .held     (ent_held[g]),
            .holder   (ent_holder[g]),
            .take_ok  (ent_take_ok[g])
        );
    end

    // request-side selection and verdict
    pfw_ctl_t         sel_ctl;
    logic             sel_held, sel_hit, req_ok;
    logic [CID_W-1:0] sel_holder;
    logic [DW-1:0]    sel_rdata;

    always_comb begin
        sel_ctl    = '0;
        sel_held   = 1'b0;
        sel_holder = '0;
        sel_rdata  = '0;
        sel_hit    = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (req_idx == IDX_W'(i)) begin
                sel_ctl    = ent_ctl[i];
                sel_held   = ent_held[i];
                sel_holder = ent_holder[i];
                sel_rdata  = slot_rdata[i*DW +: DW];
                sel_hit    = 1'b1;
            end
        end
    end

    assign req_ok = sel_hit &&
                    pfw_allow(sel_ctl, req_cid, req_sec, req_priv, sel_held, sel_holder);

    pfw_resp #(.NP(NP), .DW(DW), .IDX_W(IDX_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_cid    (req_cid),
        .req_idx    (req_idx),
        .req_wdata  (req_wdata),
        .ok         (req_ok),
        .sel_rdata  (sel_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_grant  (rsp_grant),
        .rsp_rdata  (rsp_rdata),
        .slot_we    (slot_we),
        .slot_wdata (slot_wdata),
        .ill_pulse  (ill_pulse),
        .ill_cid    (ill_cid),
        .ill_idx    (ill_idx)
    );

    // configuration read-back, open to every initiator
    logic [CFG_W-1:0] cfg_rd_nx;
    always_comb begin
        cfg_rd_nx = '0;
        for (int i = 0; i < NP; i++) begin
            if (cfg_idx == IDX_W'(i))
                cfg_rd_nx = cfg_sel ? CFG_W'(ent_take_ok[i]) : CFG_W'(ent_ctl[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_valid && !cfg_write;
            cfg_rdata  <= (cfg_valid && !cfg_write) ? cfg_rd_nx : '0;
        end
    end
endmodule

// File: rtl/pfw_top_chk.sv
module pfw_top_chk
    import pfw_pkg::*;
#(
    parameter int NP    = 4,
    parameter int DW    = 8,
    parameter int IDX_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_sec,
    input logic                req_priv,
    input logic [IDX_W-1:0]    req_idx,
    input logic                rsp_valid,
    input logic                rsp_grant,
    input logic [DW-1:0]       rsp_rdata,
    input logic [NP-1:0]       slot_we,
    input logic                ill_pulse,
    input pfw_ctl_t [NP-1:0]   ent_ctl
);
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);  // R11
    AST_ILL_ON_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (ill_pulse == !rsp_grant));  // R10
    AST_ILL_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        ill_pulse |-> rsp_valid);  // R10
    AST_BLOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> (rsp_rdata == '0));  // R10
    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_we));  // R11
    AST_WE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_we != '0) |-> (rsp_valid && rsp_grant));  // R10

    for (genvar g = 0; g < NP; g++) begin : g_chk
        AST_SEC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_idx == IDX_W'(g) && !req_sec && ent_ctl[g].sec) |=> !rsp_grant);  // R2
        AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_idx == IDX_W'(g) && !req_priv && ent_ctl[g].priv) |=> !rsp_grant);  // R3
        AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ent_ctl[g].lock |=> $stable(ent_ctl[g]));  // R9
    end
endmodule

bind pfw_top pfw_top_chk #(.NP(NP), .DW(DW), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sec   (req_sec),
    .req_priv  (req_priv),
    .req_idx   (req_idx),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_rdata (rsp_rdata),
    .slot_we   (slot_we),
    .ill_pulse (ill_pulse),
    .ent_ctl   (ent_ctl)
);

// File: tb/pfw_top_bench.sv
module pfw_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 8;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_cid = '0;
    logic              req_sec = 1'b0;
    logic              req_priv = 1'b0;
    logic [IW-1:0]     req_idx = '0;
    logic              req_write = 1'b0;
    logic [DW-1:0]     req_wdata = 8'h5A;
    logic [NP*DW-1:0]  slot_rdata = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    logic [NP-1:0]     slot_we;
    logic [DW-1:0]     slot_wdata;
    logic              rsp_valid, rsp_grant;
    logic [DW-1:0]     rsp_rdata;
    logic              ill_pulse;
    logic [2:0]        ill_cid;
    logic [IW-1:0]     ill_idx;
    logic              cfg_valid = 1'b0;
    logic              cfg_write = 1'b0;
    logic [IW:0]       cfg_addr = '0;
    logic [15:0]       cfg_wdata = '0;
    logic [2:0]        cfg_cid = '0;
    logic              cfg_sec = 1'b0;
    logic              cfg_priv = 1'b0;
    logic              cfg_rvalid;
    logic [15:0]       cfg_rdata;

    int total = 0;
    int bad = 0;
    logic [15:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfw_top #(.NP(NP), .DW(DW), .TRUST_CID(1)) u_pfw_top (.*);

    // {cid[3], sec, priv, idx[2], write, expected grant}
    localparam logic [8:0] VEC [9] = '{
        {3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
        {3'd4, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
        {3'd4, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1},
        {3'd3, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1},
        {3'd2, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0},
        {3'd1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1},
        {3'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [2:0] cid, input logic s, input logic p,
                       input logic [IW-1:0] idx, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_cid = cid; req_sec = s; req_priv = p;
        req_idx = idx; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cfg_wr(input logic [2:0] cid, input logic s, input logic p,
                          input logic [IW:0] addr, input logic [15:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_cid = cid; cfg_sec = s;
        cfg_priv = p; cfg_addr = addr; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] cid, input logic s, input logic p,
                          input logic [IW:0] addr, output logic [15:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_cid = cid; cfg_sec = s;
        cfg_priv = p; cfg_addr = addr;
        @(negedge clk);
        cfg_valid = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 ill_pulse", 32'(ill_pulse), 0);
        chk("R1 slot_we", 32'(slot_we), 0);
        cfg_rd(3'd7, 0, 0, 3'd0, rd);
        chk("R1 ctl0 reset", 32'(rd), 32'h0000);
        acc(3'd7, 0, 0, 2'd3, 0);
        chk("R1 open grant", 32'(rsp_grant), 1);
        chk("R1 R11 read data", 32'(rsp_rdata), 32'hA3);
        chk("R11 rsp_valid", 32'(rsp_valid), 1);
        @(negedge clk);
        chk("R11 single response", 32'(rsp_valid), 0);

        // trusted setup
        cfg_wr(3'd1, 1, 1, 3'd0, 16'h0001);
        cfg_wr(3'd1, 1, 1, 3'd2, 16'h0002);
        cfg_wr(3'd1, 1, 1, 3'd4, 16'h0034);
        cfg_wr(3'd1, 1, 1, 3'd6, 16'h240C);
        cfg_rd(3'd6, 0, 0, 3'd4, rd);
        chk("R12 read by any", 32'(rd), 32'h0034);

        // R7: untrusted writes refused
        cfg_wr(3'd2, 1, 1, 3'd4, 16'h00FF);
        cfg_rd(3'd0, 0, 0, 3'd4, rd);
        chk("R7 wrong cid", 32'(rd), 32'h0034);
        cfg_wr(3'd1, 0, 1, 3'd4, 16'h0000);
        cfg_rd(3'd0, 0, 0, 3'd4, rd);
        chk("R7 trusted non-secure", 32'(rd), 32'h0034);

        // table walk: R2 R3 R4 R6 R10 R11
        for (int i = 0; i < 9; i++) begin
            logic [8:0] v;
            logic [IW-1:0] ix;
            v = VEC[i];
            ix = v[3:2];
            acc(v[8:6], v[5], v[4], ix, v[1]);
            chk($sformatf("R2 R3 R4 R6 vec%0d grant", i), 32'(rsp_grant), 32'(v[0]));
            chk($sformatf("R10 vec%0d ill", i), 32'(ill_pulse), 32'(!v[0]));
            chk($sformatf("R10 R11 vec%0d rdata", i), 32'(rsp_rdata),
                (v[0] && !v[1]) ? 32'(8'hA0 + 8'(ix)) : 32'h0);
            chk($sformatf("R11 vec%0d we", i), 32'(slot_we),
                (v[0] && v[1]) ? 32'(4'b1 << ix) : 32'h0);
            if (v[0] && v[1]) chk("R11 wdata", 32'(slot_wdata), 32'h5A);
        end

        // semaphore on slot 3: listed CIDs 2 and 5
        cfg_rd(3'd2, 1, 1, 3'd7, rd);
        chk("R5 take by listed", 32'(rd), 1);
        cfg_rd(3'd5, 1, 1, 3'd7, rd);
        chk("R5 take while held", 32'(rd), 0);
        acc(3'd2, 1, 1, 2'd3, 0);
        chk("R6 holder granted", 32'(rsp_grant), 1);
        acc(3'd5, 1, 1, 2'd3, 0);
        chk("R6 non-holder blocked", 32'(rsp_grant), 0);
        chk("R10 ill_cid", 32'(ill_cid), 5);
        chk("R10 ill_idx", 32'(ill_idx), 3);
        cfg_wr(3'd5, 1, 1, 3'd7, 16'h0000);
        acc(3'd2, 1, 1, 2'd3, 0);
        chk("R6 release by non-holder ignored", 32'(rsp_grant), 1);
        cfg_wr(3'd2, 1, 1, 3'd7, 16'h0000);
        acc(3'd2, 1, 1, 2'd3, 0);
        chk("R6 released blocks old holder", 32'(rsp_grant), 0);
        cfg_rd(3'd6, 1, 1, 3'd7, rd);
        chk("R5 unlisted take", 32'(rd), 0);
        cfg_rd(3'd5, 1, 1, 3'd7, rd);
        chk("R5 second listed take", 32'(rd), 1);
        acc(3'd5, 0, 0, 2'd3, 0);
        chk("R6 new holder granted", 32'(rsp_grant), 1);

        // R8 delegation on slot 0 (secure-only)
        cfg_wr(3'd5, 1, 0, 3'd0, 16'h0004);
        cfg_rd(3'd0, 0, 0, 3'd0, rd);
        chk("R8 secure clears sec only", 32'(rd), 32'h0000);
        cfg_wr(3'd5, 0, 1, 3'd0, 16'h0003);
        cfg_rd(3'd0, 0, 0, 3'd0, rd);
        chk("R8 privileged sets priv only", 32'(rd), 32'h0002);

        // R10 blocked write
        acc(3'd6, 0, 0, 2'd0, 1);
        chk("R10 blocked write we", 32'(slot_we), 0);
        chk("R10 blocked write ill", 32'(ill_pulse), 1);
        chk("R10 ill_cid", 32'(ill_cid), 6);
        chk("R10 ill_idx", 32'(ill_idx), 0);
        @(negedge clk);
        chk("R10 pulse one cycle", 32'(ill_pulse), 0);
        chk("R10 ill_cid held", 32'(ill_cid), 6);

        // same-cycle config write and access on slot 2
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_cid = 3'd1; cfg_sec = 1'b1;
        cfg_priv = 1'b1; cfg_addr = 3'd4; cfg_wdata = 16'h0001;
        req_valid = 1'b1; req_cid = 3'd3; req_sec = 1'b0; req_priv = 1'b0;
        req_idx = 2'd2; req_write = 1'b0;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0; req_valid = 1'b0;
        chk("R4 old config judged", 32'(rsp_grant), 1);
        acc(3'd3, 0, 0, 2'd2, 0);
        chk("R2 new config applied", 32'(rsp_grant), 0);

        // R9 lock on slot 1
        cfg_wr(3'd1, 1, 1, 3'd2, 16'h0082);
        cfg_wr(3'd1, 1, 1, 3'd2, 16'h0000);
        cfg_rd(3'd0, 0, 0, 3'd2, rd);
        chk("R9 locked word", 32'(rd), 32'h0082);
        acc(3'd4, 0, 0, 2'd1, 0);
        chk("R9 locked still blocks", 32'(rsp_grant), 0);
        do_reset();
        cfg_rd(3'd0, 0, 0, 3'd2, rd);
        chk("R9 R1 reset clears lock", 32'(rd), 32'h0000);
        acc(3'd4, 0, 0, 2'd1, 0);
        chk("R1 open after reset", 32'(rsp_grant), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule